// File: doc/BRIEF.md
# In-Group Store-to-Load Overlap Detector

This block watches the memory accesses issued into one dispatch group. It records each store and checks every later load in the same group against all recorded stores in parallel. It raises `noopNeeded` when the load may read bytes that one of those stores wrote. A scheduler uses this signal to close the group, or to insert a no-op, before the load goes in.

Addresses are never computed. An access is described by two operand tags: a first operand, which is either an immediate offset or an index register, and a base register. A flag marks the first operand as a constant, and that constant's signed value travels with the access. A size code gives the access width. Tags that are identical in the same order, or in swapped order, count as a match. When the base tags agree and both first operands are constants, the two byte ranges are compared for overlap. A group-end strobe empties the table.

Top module: `grp_ldst_overlap`

## Requirements
- R1: `accSizeCode` encodes the access width as 1 << code bytes: code 0 is 1 byte, 1 is 2, 2 is 4, 3 is 8 and 4 is 16. Codes 5 to 7 are not used.
- R2: A load whose `accOpA`/`accOpB` equal a recorded store's first/base tags, in that order, asserts `noopNeeded` in the same cycle.
- R3: A load whose first tag equals a recorded store's base tag, and whose base tag equals that store's first tag, also asserts `noopNeeded`.
- R4: When the base tags match and both accesses have constant first operands, the offsets are taken as signed 16-bit values. If the store offset is strictly lower, the accesses overlap when store offset + store bytes > load offset. Otherwise they overlap when load offset + load bytes > store offset. An overlap asserts `noopNeeded`. If the base tags match, either offset is non-constant, and neither tag match holds, there is no match.
- R5: `noopNeeded` is high only when `accValid`=1 and `accIsStore`=0 and at least one store is recorded. Store cycles and idle cycles never assert it.
- R6: A store (`accValid`=1, `accIsStore`=1) is appended at the clock edge that ends its cycle. A load sees it from the next cycle on.
- R7: `groupEnd` empties the table at the edge that ends its cycle. A load in that same cycle is still checked against the current table. A store in that same cycle is not recorded.
- R8: The table holds 5 entries. A store that arrives while 5 are recorded is ignored.
- R9: Reset (`rstN`=0, asynchronous) empties the table immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accIsStore | input | 1 | 1 = store, 0 = load |
| accOpA | input | TAG_W | First operand tag (offset or index register) |
| accOpB | input | TAG_W | Base register tag |
| accAConst | input | 1 | First operand is an immediate constant |
| accOffset | input | OFF_W | Signed constant offset, used when accAConst=1 |
| accSizeCode | input | 3 | Access width code, bytes = 1 << code |
| groupEnd | input | 1 | Current dispatch group closes at this edge |
| noopNeeded | output | 1 | The presented load may read a store from this group |

## Verification
The hardest case to reach is the full table. Five stores have to land in one group with no `groupEnd` between them, and then a sixth store plus a load that matches only that sixth store must follow. A random phase with a low group-end rate, a small tag alphabet and offsets clustered around zero therefore mixes with directed sequences. These fill the table, test adjacent and negative offset ranges against their exact boundaries, and place a load and a store in the same cycle as `groupEnd`. A behavioural queue model predicts `noopNeeded` on every cycle.

// File: rtl/ovlp_pkg.sv
package ovlp_pkg;

  // Strobes from control to the entry table.
  typedef struct packed {
    logic wrEn;
    logic clr;
  } tblStrobe_t;

  localparam int SIZE_CODE_W = 3;

endpackage

// File: rtl/ovlp_ctrl.sv
module ovlp_ctrl
  import ovlp_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             storeReq,
  input  logic             groupEnd,
  output tblStrobe_t       strobe,
  output logic [CNT_W-1:0] wrIdx,
  output logic [DEPTH-1:0] validMask,
  output logic [CNT_W-1:0] storeCount
);

  logic [CNT_W-1:0] count;
  logic             roomLeft;

  assign roomLeft = (count < CNT_W'(DEPTH));

  always_comb begin
    strobe.clr  = groupEnd;
    strobe.wrEn = storeReq & ~groupEnd & roomLeft;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.clr) begin
      count <= '0;
    end else if (strobe.wrEn) begin
      count <= count + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    assign validMask[i] = (count > CNT_W'(i));
  end

  assign wrIdx      = count;
  assign storeCount = count;

endmodule

// File: rtl/ovlp_datapath.sv
module ovlp_datapath
  import ovlp_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int TAG_W = 6,
  parameter int OFF_W = 16,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tblStrobe_t             strobe,
  input  logic [CNT_W-1:0]       wrIdx,
  input  logic [DEPTH-1:0]       validMask,
  input  logic                   isLoad,
  input  logic [TAG_W-1:0]       inOpA,
  input  logic [TAG_W-1:0]       inOpB,
  input  logic                   inAConst,
  input  logic [OFF_W-1:0]       inOffset,
  input  logic [SIZE_CODE_W-1:0] inSizeCode,
  output logic                   hit
);

  localparam int SUM_W = OFF_W + 1;

  logic [TAG_W-1:0]       entOpA   [DEPTH];
  logic [TAG_W-1:0]       entOpB   [DEPTH];
  logic                   entConst [DEPTH];
  logic [OFF_W-1:0]       entOff   [DEPTH];
  logic [SIZE_CODE_W-1:0] entSize  [DEPTH];
  logic [DEPTH-1:0]       matchVec;

  // Incoming load range, sign-extended by one bit so the end never wraps.
  logic signed [SUM_W-1:0] ldLo, ldHi, ldBytes;
  assign ldBytes = SUM_W'(1) << inSizeCode;
  assign ldLo    = {inOffset[OFF_W-1], inOffset};
  assign ldHi    = ldLo + ldBytes;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic                    sameOrder, swapOrder, baseEq, bothConst, rangeHit;
    logic signed [SUM_W-1:0] stLo, stHi, stBytes;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entOpA[i]   <= '0;
        entOpB[i]   <= '0;
        entConst[i] <= 1'b0;
        entOff[i]   <= '0;
        entSize[i]  <= '0;
      end else if (strobe.wrEn && (wrIdx == CNT_W'(i))) begin
        entOpA[i]   <= inOpA;
        entOpB[i]   <= inOpB;
        entConst[i] <= inAConst;
        entOff[i]   <= inOffset;
        entSize[i]  <= inSizeCode;
      end
    end

    assign stBytes   = SUM_W'(1) << entSize[i];
    assign stLo      = {entOff[i][OFF_W-1], entOff[i]};
    assign stHi      = stLo + stBytes;
    assign sameOrder = (inOpA == entOpA[i]) && (inOpB == entOpB[i]);
    assign swapOrder = (inOpA == entOpB[i]) && (inOpB == entOpA[i]);
    assign baseEq    = (inOpB == entOpB[i]);
    assign bothConst = inAConst & entConst[i];
    assign rangeHit  = (stLo < ldLo) ? (stHi > ldLo) : (ldHi > stLo);

    assign matchVec[i] = validMask[i] &
                         (sameOrder | swapOrder | (baseEq & bothConst & rangeHit));
  end

  assign hit = isLoad & (|matchVec);

endmodule

// File: rtl/grp_ldst_overlap.sv
module grp_ldst_overlap
  import ovlp_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int TAG_W = 6,
  parameter int OFF_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   accValid,
  input  logic                   accIsStore,
  input  logic [TAG_W-1:0]       accOpA,
  input  logic [TAG_W-1:0]       accOpB,
  input  logic                   accAConst,
  input  logic [OFF_W-1:0]       accOffset,
  input  logic [SIZE_CODE_W-1:0] accSizeCode,
  input  logic                   groupEnd,
  output logic                   noopNeeded
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  tblStrobe_t       strobe;
  logic [CNT_W-1:0] wrIdx;
  logic [DEPTH-1:0] validMask;
  logic [CNT_W-1:0] storeCount;
  logic             storeReq, isLoad;

  assign storeReq = accValid & accIsStore;
  assign isLoad   = accValid & ~accIsStore;

  ovlp_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .storeReq(storeReq), .groupEnd(groupEnd),
    .strobe(strobe), .wrIdx(wrIdx), .validMask(validMask),
    .storeCount(storeCount)
  );

  ovlp_datapath #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .validMask(validMask), .isLoad(isLoad), .inOpA(accOpA), .inOpB(accOpB),
    .inAConst(accAConst), .inOffset(accOffset), .inSizeCode(accSizeCode),
    .hit(noopNeeded)
  );

endmodule

// File: rtl/ovlp_checker.sv
module ovlp_checker #(
  parameter int DEPTH = 5,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             accValid,
  input logic             accIsStore,
  input logic             groupEnd,
  input logic             noopNeeded,
  input logic [CNT_W-1:0] storeCount
);

  a_r5_store_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accIsStore) |-> !noopNeeded);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> !noopNeeded);

  a_r6_append_counts: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accIsStore && !groupEnd && (storeCount < CNT_W'(DEPTH)))
      |=> (storeCount == CNT_W'($past(storeCount) + 1)));

  a_r7_end_clears: assert property (@(posedge clk) disable iff (!rstN)
    groupEnd |=> (storeCount == '0));

  a_r7_no_hit_after_end: assert property (@(posedge clk) disable iff (!rstN)
    groupEnd |=> !noopNeeded);

  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accIsStore && !groupEnd && (storeCount == CNT_W'(DEPTH)))
      |=> (storeCount == CNT_W'(DEPTH)));

  a_r8_bounded: assert property (@(posedge clk) disable iff (!rstN)
    storeCount <= CNT_W'(DEPTH));

endmodule

bind grp_ldst_overlap ovlp_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accIsStore(accIsStore),
  .groupEnd(groupEnd), .noopNeeded(noopNeeded), .storeCount(storeCount)
);

// File: tb/grp_ldst_overlap_bench.sv
module grp_ldst_overlap_bench;
  localparam int TAG_W = 6;
  localparam int OFF_W = 16;
  localparam int DEPTH = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN, accValid, accIsStore, accAConst, groupEnd, noopNeeded;
  logic [TAG_W-1:0] accOpA, accOpB;
  logic [OFF_W-1:0] accOffset;
  logic [2:0]       accSizeCode;

  grp_ldst_overlap #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_grp_ldst_overlap (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accIsStore(accIsStore),
    .accOpA(accOpA), .accOpB(accOpB), .accAConst(accAConst),
    .accOffset(accOffset), .accSizeCode(accSizeCode), .groupEnd(groupEnd),
    .noopNeeded(noopNeeded)
  );

  typedef struct { int a; int b; bit c; int off; int bytes; } ent_t;
  ent_t tbl[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  function automatic bit modelHit();
    int lo, lb;
    if (!accValid || accIsStore) return 0;
    lo = $signed(accOffset);
    lb = 1 << accSizeCode;                      // R1 byte count
    foreach (tbl[i]) begin
      if (tbl[i].a == int'(accOpA) && tbl[i].b == int'(accOpB)) return 1;
      if (tbl[i].b == int'(accOpA) && tbl[i].a == int'(accOpB)) return 1;
      if (tbl[i].b == int'(accOpB) && tbl[i].c && accAConst) begin
        if (tbl[i].off < lo) begin
          if (tbl[i].off + tbl[i].bytes > lo) return 1;
        end else if (lo + lb > tbl[i].off) return 1;
      end
    end
    return 0;
  endfunction

  task automatic step(input bit v, input bit st, input bit ge, input bit ac,
                      input int a, input int b, input int off, input int code,
                      input string req);
    bit exp;
    accValid = v; accIsStore = st; groupEnd = ge; accAConst = ac;
    accOpA = TAG_W'(a); accOpB = TAG_W'(b);
    accOffset = OFF_W'(off); accSizeCode = 3'(code);
    if (!rstN) tbl.delete();
    #1;
    exp = modelHit();
    checks++;
    if (noopNeeded !== exp) begin
      errors++;
      $display("FAIL %s noopNeeded actual=%0b expected=%0b", req, noopNeeded, exp);
    end
    @(posedge clk);
    if (!rstN || ge) tbl.delete();
    else if (v && st && tbl.size() < DEPTH)
      tbl.push_back('{a: a, b: b, c: ac, off: off, bytes: 1 << code});
    @(negedge clk);
  endtask

  task automatic st(input int a, input int b, input bit ac, input int off, input int code);
    step(1, 1, 0, ac, a, b, off, code, "R6");
  endtask
  task automatic ld(input int a, input int b, input bit ac, input int off, input int code,
                    input string req);
    step(1, 0, 0, ac, a, b, off, code, req);
  endtask
  task automatic endGrp();
    step(0, 0, 1, 0, 0, 0, 0, 0, "R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; accValid = 0; accIsStore = 0; groupEnd = 0; accAConst = 0;
    accOpA = '0; accOpB = '0; accOffset = '0; accSizeCode = '0;
    @(negedge clk);
    step(1, 0, 0, 0, 3, 7, 0, 2, "R9 reset");
    rstN = 1;
    ld(3, 7, 0, 0, 2, "R5 empty table");
    // R2 / R3 / R6
    ld(3, 7, 0, 0, 2, "R6 before store");
    st(3, 7, 0, 0, 2);
    ld(3, 7, 0, 0, 2, "R2 same order");
    ld(7, 3, 0, 0, 2, "R3 swapped");
    ld(3, 8, 0, 0, 2, "R2 different base");
    step(1, 1, 0, 0, 3, 7, 0, 2, "R5 store never flags");
    step(0, 0, 0, 0, 3, 7, 0, 2, "R5 idle never flags");
    endGrp();
    // R4 / R1 range overlap, store offset 8, 4 bytes, base 9
    st(20, 9, 1, 8, 2);
    ld(21, 9, 1, 10, 1, "R4 inside");
    ld(21, 9, 1, 12, 2, "R4 adjacent above");
    ld(21, 9, 1, 4, 2, "R4 adjacent below");
    ld(21, 9, 1, 5, 2, "R4 overlap below");
    ld(21, 9, 1, 0, 3, "R1 eight bytes end at 8");
    ld(21, 9, 1, 1, 3, "R1 eight bytes reach 8");
    ld(22, 9, 0, 10, 1, "R4 non-constant base match");
    endGrp();
    st(20, 11, 1, -4, 4);
    ld(21, 11, 1, 11, 0, "R1 sixteen bytes negative");
    ld(21, 11, 1, 12, 0, "R1 sixteen bytes edge");
    ld(21, 11, 1, -20, 4, "R4 negative load adjacent");
    ld(21, 11, 1, -19, 4, "R4 negative load overlap");
    // R7 same-cycle load and store with group end
    step(1, 0, 1, 1, 21, 11, 11, 0, "R7 load in end cycle");
    ld(21, 11, 1, 11, 0, "R7 after end");
    step(1, 1, 1, 0, 30, 31, 0, 2, "R7 store in end cycle");
    ld(30, 31, 0, 0, 2, "R7 store dropped");
    // R8 full table
    for (int i = 0; i < 6; i++) st(40 + i, 50 + i, 0, 0, 2);
    ld(44, 54, 0, 0, 2, "R8 fifth entry");
    ld(45, 55, 0, 0, 2, "R8 sixth ignored");
    endGrp();
    // R9 reset empties a populated table
    st(1, 2, 0, 0, 0);
    rstN = 0;
    ld(1, 2, 0, 0, 0, "R9 during reset");
    rstN = 1;
    ld(1, 2, 0, 0, 0, "R9 after reset");
    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 85, $urandom_range(0, 99) < 40, $urandom_range(0, 99) < 8,
           $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
           int'($urandom_range(0, 24)) - 12, $urandom_range(0, 4), "R4 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule